// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the slave-side serial front end of a small NOR flash model. It watches a serial clock, a data-in line and an active-low chip select, all oversampled by the system clock. It packs the incoming bits into 8-bit bus cycles and decodes the first one as the opcode. It then collects the address, dummy and data cycles that the opcode calls for. Read-type commands get a byte stream on the data-out line, with an output enable that stands in for the tri-state control. Commands that change the array or the status reach a backend as a one-cycle request that carries a kind code, a 24-bit address and up to two data bytes.

A write-enable latch inside the block gates every modifying command. A malformed frame, or one cut off partway through a bus cycle, leaves both the backend and the latch untouched. Array data for reads comes from a backend read port. The block puts out the address and takes back a byte that must be valid within half a serial clock period.

Top module: `spi_flash_front`

## Requirements
- R1: Bits are sampled on rising serial-clock edges, most significant bit first, in 8-bit bus cycles. The first bus cycle after chip select falls is the opcode.
- R2: If chip select rises before the eighth bit of a bus cycle, the frame is discarded. No request is issued and the write-enable latch keeps its value.
- R3: Opcode 06h sets the write-enable latch and 04h clears it. Each acts only when the frame is exactly one bus cycle long. The latch is 0 after reset and shows as bit 1 of the status byte.
- R4: A program, erase or status-write frame that arrives while the latch is 0 issues no request.
- R5: Byte program (02h) followed by exactly three address bytes and one data byte issues a request with kind 0, the address, and data {00h, byte} on the clock after the rise of chip select is seen. Every issued request also clears the latch. A frame of any other length issues nothing.
- R6: Opcodes 20h, 52h and D8h, each followed by exactly three address bytes, issue kinds 1, 2 and 3. The address comes with its low 12, 15 or 16 bits forced to zero.
- R7: Opcode 60h or C7h, as a one-byte frame, issues kind 4 with address 0.
- R8: Opcode 01h followed by one data byte issues kind 5 with data {00h, b0} and the two-byte flag clear. Followed by two data bytes it issues data {b0, b1} with the flag set.
- R9: Opcode 03h followed by three address bytes streams array bytes from that address upward, wrapping at 24 bits. The first data bit is driven on the falling edge right after the last address bit.
- R10: Opcode 0Bh inserts one dummy bus cycle between the address and the data stream.
- R11: Opcode 05h repeats the status byte {stat_hi, latch, busy_i}. Opcode 35h repeats cfg_i. Both continue while the clock runs.
- R12: Opcodes 90h and ABh take three address bytes. They then output the device ID if address bit 0 is 1 and the manufacturer ID if it is 0, and alternate between the two from then on.
- R13: Opcode 9Fh outputs the three ID bytes (most significant first) and repeats them.
- R14: Any other opcode keeps the output enable low until chip select rises, issues no request and leaves the latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock, synchronous to clk |
| csn | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so (0 = high impedance) |
| busy_i | input | 1 | Busy flag shown as status bit 0 |
| stat_hi | input | 6 | Status bits 7..2 |
| cfg_i | input | 8 | Byte returned by opcode 35h |
| rd_addr | output | 24 | Array read address |
| rd_data | input | 8 | Array byte at rd_addr |
| wel | output | 1 | Write-enable latch |
| req_valid | output | 1 | One-cycle request strobe |
| req_kind | output | 3 | 0 program, 1/2/3 erase 4K/32K/64K, 4 chip erase, 5 status write |
| req_addr | output | 24 | Request address (erase masked) |
| req_data | output | 16 | Request data |
| req_two | output | 1 | Status write carried two bytes |

## Verification
The checks assume that sck, csn and si are already synchronous to clk and that each serial-clock phase lasts at least two system clocks. They also assume that chip select never changes in the same clock as a serial-clock edge and that it stays high for at least two clocks between frames. Under those conditions a request appears only while chip select is high, and the output enable is never seen one clock into a deselect. The stimulus changes every input on the falling edge of clk. It uses three-clock serial half-periods and leaves idle clocks around each chip-select transition, so it stays inside these limits.

// File: rtl/spi_fd_pkg.sv
package spi_fd_pkg;
  localparam int BYTE_BITS  = 8;
  localparam int BIT_W      = $clog2(BYTE_BITS);
  localparam int ADDR_BYTES = 3;
  localparam int ADDR_W     = ADDR_BYTES * BYTE_BITS;
  localparam int CNT_W      = 3;

  typedef enum logic [3:0] {
    K_NONE, K_ARRAY, K_STAT, K_CFG, K_RDID, K_JEDEC,
    K_WREN, K_WRDI, K_PROG, K_ERASE, K_CHIP, K_WRSR
  } cmd_kind_e;

  typedef struct packed {
    cmd_kind_e  kind;
    logic [1:0] n_addr;
    logic       n_dummy;
    logic [2:0] req_code;
    logic [4:0] mask_bits;
  } op_attr_t;
endpackage

// File: rtl/spi_fd_optable.sv
module spi_fd_optable
  import spi_fd_pkg::*;
(
  input  logic [7:0] op,
  output op_attr_t   attr
);
  always_comb begin
    attr = '{kind: K_NONE, n_addr: 2'd0, n_dummy: 1'b0, req_code: 3'd0, mask_bits: 5'd0};
    case (op)
      8'h03: begin attr.kind = K_ARRAY; attr.n_addr = 2'(ADDR_BYTES); end
      8'h0B: begin attr.kind = K_ARRAY; attr.n_addr = 2'(ADDR_BYTES); attr.n_dummy = 1'b1; end
      8'h05: attr.kind = K_STAT;
      8'h35: attr.kind = K_CFG;
      8'h90, 8'hAB: begin attr.kind = K_RDID; attr.n_addr = 2'(ADDR_BYTES); end
      8'h9F: attr.kind = K_JEDEC;
      8'h06: attr.kind = K_WREN;
      8'h04: attr.kind = K_WRDI;
      8'h02: begin attr.kind = K_PROG; attr.n_addr = 2'(ADDR_BYTES); attr.req_code = 3'd0; end
      8'h20: begin attr.kind = K_ERASE; attr.n_addr = 2'(ADDR_BYTES); attr.req_code = 3'd1; attr.mask_bits = 5'd12; end
      8'h52: begin attr.kind = K_ERASE; attr.n_addr = 2'(ADDR_BYTES); attr.req_code = 3'd2; attr.mask_bits = 5'd15; end
      8'hD8: begin attr.kind = K_ERASE; attr.n_addr = 2'(ADDR_BYTES); attr.req_code = 3'd3; attr.mask_bits = 5'd16; end
      8'h60, 8'hC7: begin attr.kind = K_CHIP; attr.req_code = 3'd4; end
      8'h01: begin attr.kind = K_WRSR; attr.req_code = 3'd5; end
      default: ;
    endcase
  end
endmodule

// File: rtl/spi_fd_shifter.sv
module spi_fd_shifter
  import spi_fd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sck,
  input  logic             csn,
  input  logic             si,
  output logic             sck_fall,
  output logic             cs_fall,
  output logic             cs_rise,
  output logic             byte_stb,
  output logic [7:0]       byte_val,
  output logic [CNT_W-1:0] byte_idx,
  output logic             mid_cycle
);
  logic             sck_q, cs_q, sck_rise;
  logic [6:0]       sh;
  logic [BIT_W-1:0] bit_cnt;
  logic [CNT_W-1:0] cnt;

  assign sck_rise  = ~csn & sck & ~sck_q;
  assign sck_fall  = ~csn & ~sck & sck_q;
  assign cs_fall   = ~csn & cs_q;
  assign cs_rise   = csn & ~cs_q;
  assign byte_stb  = sck_rise && (bit_cnt == BIT_W'(BYTE_BITS - 1));
  assign byte_val  = {sh, si};
  assign byte_idx  = cnt;
  assign mid_cycle = (bit_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q   <= 1'b0;
      cs_q    <= 1'b1;
      sh      <= '0;
      bit_cnt <= '0;
      cnt     <= '0;
    end else begin
      sck_q <= sck;
      cs_q  <= csn;
      if (cs_fall) begin
        bit_cnt <= '0;
        cnt     <= '0;
      end else if (sck_rise) begin
        sh      <= {sh[5:0], si};
        bit_cnt <= bit_cnt + 1'b1;
        if (byte_stb && cnt != '1) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_fd_tx.sv
module spi_fd_tx
  import spi_fd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       csn,
  input  logic       sck_fall,
  input  logic       arm,
  input  logic [7:0] load_byte,
  output logic       load_take,
  output logic       so,
  output logic       so_oe
);
  logic             active;
  logic [BIT_W-1:0] cnt;
  logic [6:0]       sr;

  assign load_take = active && sck_fall && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || csn) begin
      active <= 1'b0;
      cnt    <= '0;
      sr     <= '0;
      so     <= 1'b0;
      so_oe  <= 1'b0;
    end else if (arm) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active && sck_fall) begin
      so_oe <= 1'b1;
      if (cnt == '0) begin
        so  <= load_byte[7];
        sr  <= load_byte[6:0];
        cnt <= BIT_W'(BYTE_BITS - 1);
      end else begin
        so  <= sr[6];
        sr  <= {sr[5:0], 1'b0};
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_flash_front.sv
module spi_flash_front
  import spi_fd_pkg::*;
#(
  parameter logic [7:0]  MFR_ID   = 8'hBF,
  parameter logic [7:0]  DEV_ID   = 8'h8C,
  parameter logic [23:0] JEDEC_ID = 24'hBF258C
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sck,
  input  logic        csn,
  input  logic        si,
  output logic        so,
  output logic        so_oe,
  input  logic        busy_i,
  input  logic [5:0]  stat_hi,
  input  logic [7:0]  cfg_i,
  output logic [23:0] rd_addr,
  input  logic [7:0]  rd_data,
  output logic        wel,
  output logic        req_valid,
  output logic [2:0]  req_kind,
  output logic [23:0] req_addr,
  output logic [15:0] req_data,
  output logic        req_two
);
  localparam logic [CNT_W-1:0] LEN_PROG  = CNT_W'(ADDR_BYTES + 2);
  localparam logic [CNT_W-1:0] LEN_ERASE = CNT_W'(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] LEN_ONE   = CNT_W'(1);

  logic             sck_fall, cs_fall, cs_rise, byte_stb, mid_cycle;
  logic [7:0]       byte_val, op_q, op_sel, tx_byte;
  logic [CNT_W-1:0] byte_idx, n_addr, hdr_last;
  op_attr_t         attr;
  logic [ADDR_W-1:0] addr_q, amask;
  logic [15:0]      data_q;
  logic             id_sel, is_read, arm, load_take, issue;
  logic [1:0]       jidx;

  spi_fd_shifter u_shift (
    .clk(clk), .rst(rst), .sck(sck), .csn(csn), .si(si),
    .sck_fall(sck_fall), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .byte_stb(byte_stb), .byte_val(byte_val), .byte_idx(byte_idx),
    .mid_cycle(mid_cycle)
  );

  assign op_sel = (byte_idx == '0) ? byte_val : op_q;

  spi_fd_optable u_table (.op(op_sel), .attr(attr));

  assign n_addr   = CNT_W'(attr.n_addr);
  assign hdr_last = n_addr + CNT_W'(attr.n_dummy);
  assign amask    = ~((ADDR_W'(1) << attr.mask_bits) - ADDR_W'(1));
  assign is_read  = attr.kind inside {K_ARRAY, K_STAT, K_CFG, K_RDID, K_JEDEC};
  assign arm      = byte_stb && is_read && (byte_idx == hdr_last);

  always_comb begin
    case (attr.kind)
      K_ARRAY: tx_byte = rd_data;
      K_STAT:  tx_byte = {stat_hi, wel, busy_i};
      K_CFG:   tx_byte = cfg_i;
      K_RDID:  tx_byte = id_sel ? DEV_ID : MFR_ID;
      K_JEDEC: tx_byte = (jidx == 2'd0) ? JEDEC_ID[23:16] :
                         (jidx == 2'd1) ? JEDEC_ID[15:8] : JEDEC_ID[7:0];
      default: tx_byte = 8'h00;
    endcase
  end

  always_comb begin
    case (attr.kind)
      K_PROG:  issue = (byte_idx == LEN_PROG);
      K_ERASE: issue = (byte_idx == LEN_ERASE);
      K_CHIP:  issue = (byte_idx == LEN_ONE);
      K_WRSR:  issue = (byte_idx == CNT_W'(2)) || (byte_idx == CNT_W'(3));
      default: issue = 1'b0;
    endcase
  end

  spi_fd_tx u_tx (
    .clk(clk), .rst(rst), .csn(csn), .sck_fall(sck_fall), .arm(arm),
    .load_byte(tx_byte), .load_take(load_take), .so(so), .so_oe(so_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q      <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      rd_addr   <= '0;
      id_sel    <= 1'b0;
      jidx      <= '0;
      wel       <= 1'b0;
      req_valid <= 1'b0;
      req_kind  <= '0;
      req_addr  <= '0;
      req_data  <= '0;
      req_two   <= 1'b0;
    end else begin
      req_valid <= 1'b0;
      if (cs_fall) begin
        addr_q <= '0;
        data_q <= '0;
        jidx   <= '0;
      end
      if (byte_stb) begin
        if (byte_idx == '0) begin
          op_q <= byte_val;
        end else if (byte_idx <= n_addr) begin
          addr_q <= {addr_q[ADDR_W-9:0], byte_val};
          if (byte_idx == n_addr) begin
            rd_addr <= {addr_q[ADDR_W-9:0], byte_val};
            id_sel  <= byte_val[0];
          end
        end else if (byte_idx > hdr_last) begin
          data_q <= {data_q[7:0], byte_val};
        end
      end
      if (load_take) begin
        rd_addr <= rd_addr + 1'b1;
        id_sel  <= ~id_sel;
        jidx    <= (jidx == 2'd2) ? 2'd0 : jidx + 2'd1;
      end
      if (cs_rise && !mid_cycle) begin
        if (attr.kind == K_WREN && byte_idx == LEN_ONE) wel <= 1'b1;
        if (attr.kind == K_WRDI && byte_idx == LEN_ONE) wel <= 1'b0;
        if (issue && wel) begin
          req_valid <= 1'b1;
          wel       <= 1'b0;
          req_kind  <= attr.req_code;
          req_addr  <= addr_q & amask;
          req_data  <= data_q;
          req_two   <= (byte_idx == CNT_W'(3));
        end
      end
    end
  end
endmodule

// File: rtl/spi_flash_front_chk.sv
module spi_flash_front_chk (
  input logic        clk,
  input logic        rst,
  input logic        csn,
  input logic        so_oe,
  input logic        wel,
  input logic        req_valid,
  input logic [2:0]  req_kind,
  input logic [15:0] req_addr
);
  p_req_single_r5: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid);
  p_req_gated_r4: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> $past(wel));
  p_wel_cleared_r5: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !wel);
  p_req_deselected_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (csn && $past(csn)));
  p_erase4k_align_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 3'd1) |-> (req_addr[11:0] == 12'h000));
  p_erase64k_align_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 3'd3) |-> (req_addr == 16'h0000));
  p_oe_idle_r14: assert property (@(posedge clk) disable iff (rst)
    (csn && $past(csn)) |-> !so_oe);
endmodule

bind spi_flash_front spi_flash_front_chk u_chk (
  .clk(clk), .rst(rst), .csn(csn), .so_oe(so_oe), .wel(wel),
  .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr[15:0])
);

// File: tb/spi_flash_front_tb.sv
module spi_flash_front_tb;
  localparam int HALF = 3;
  logic clk = 1'b0, rst = 1'b1, sck = 1'b0, csn = 1'b1, si = 1'b0;
  logic so, so_oe, wel, req_valid, req_two;
  logic [2:0] req_kind;
  logic [23:0] rd_addr, req_addr;
  logic [15:0] req_data;
  logic [7:0] rd_data;
  logic busy_i = 1'b1;
  logic [5:0] stat_hi = 6'b101001;
  logic [7:0] cfg_i = 8'h3C;
  int n_chk = 0, n_fail = 0;
  logic got_req = 1'b0, oe_seen = 1'b0;
  logic [2:0] c_kind; logic [23:0] c_addr; logic [15:0] c_data; logic c_two;

  always #5 clk = ~clk;

  function automatic logic [7:0] arr(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction
  assign rd_data = arr(rd_addr);

  spi_flash_front u_dut (
    .clk(clk), .rst(rst), .sck(sck), .csn(csn), .si(si), .so(so), .so_oe(so_oe),
    .busy_i(busy_i), .stat_hi(stat_hi), .cfg_i(cfg_i), .rd_addr(rd_addr),
    .rd_data(rd_data), .wel(wel), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_data(req_data), .req_two(req_two)
  );

  always @(negedge clk) begin
    if (req_valid) begin
      got_req = 1'b1; c_kind = req_kind; c_addr = req_addr; c_data = req_data; c_two = req_two;
    end
    if (so_oe) oe_seen = 1'b1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk); si = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = so; sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic xb(input logic [7:0] tx, output logic [7:0] rx);
    bits(tx, 8, rx);
  endtask

  task automatic cs_on();
    @(posedge clk); got_req = 1'b0; oe_seen = 1'b0;
    @(negedge clk); csn = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_off();
    repeat (2) @(negedge clk); csn = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                       input logic [7:0] b3, input logic [7:0] b4, input logic [7:0] b5, input int n);
    logic [7:0] r;
    logic [7:0] v [6];
    v[0] = b0; v[1] = b1; v[2] = b2; v[3] = b3; v[4] = b4; v[5] = b5;
    cs_on();
    for (int i = 0; i < n; i++) xb(v[i], r);
    cs_off();
  endtask

  task automatic rd_stat(input logic [7:0] op, output logic [7:0] s);
    logic [7:0] r;
    cs_on(); xb(op, r); xb(8'h00, s); cs_off();
  endtask

  task automatic wren(); frame(8'h06, 0, 0, 0, 0, 0, 1); endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r, s;
    logic [23:0] a;
    logic [7:0] eops [3];
    logic [23:0] eaddr [4];
    logic [4:0] emask [3];
    logic [7:0] known [16];
    logic skip;
    eops[0] = 8'h20; eops[1] = 8'h52; eops[2] = 8'hD8;
    emask[0] = 5'd12; emask[1] = 5'd15; emask[2] = 5'd16;
    eaddr[0] = 24'h000000; eaddr[1] = 24'hFFFFFF; eaddr[2] = 24'h12ABCD; eaddr[3] = 24'h038FFF;
    known = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h0B, 8'h20,
              8'h35, 8'h52, 8'h60, 8'h90, 8'h9F, 8'hAB, 8'hC7, 8'hD8};
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R3 reset state
    chk("R3 wel after reset", wel, 0);
    chk("R14 so_oe after reset", so_oe, 0);
    chk("R5 no request after reset", req_valid, 0);

    // R11 status, R1 framing of a read
    cs_on(); xb(8'h05, r); xb(0, s); xb(0, r); cs_off();
    chk("R11 status first", s, 8'hA5);
    chk("R11 status repeat", r, 8'hA5);
    wren();
    rd_stat(8'h05, s);
    chk("R3 latch set in status", s, 8'hA7);
    cs_on(); xb(8'h35, r);
    for (int i = 0; i < 3; i++) begin xb(0, r); chk("R11 cfg stream", r, 8'h3C); end
    cs_off();
    frame(8'h06, 8'h00, 0, 0, 0, 0, 2);
    frame(8'h04, 0, 0, 0, 0, 0, 1);
    rd_stat(8'h05, s);
    chk("R3 write disable", s, 8'hA5);
    frame(8'h06, 8'h00, 0, 0, 0, 0, 2);
    rd_stat(8'h05, s);
    chk("R3 long enable frame ignored", s, 8'hA5);

    // R4 gating
    frame(8'h02, 8'h12, 8'h34, 8'h56, 8'h9A, 0, 5);
    chk("R4 program without latch", got_req, 0);
    frame(8'hC7, 0, 0, 0, 0, 0, 1);
    chk("R4 chip erase without latch", got_req, 0);

    // R5 program
    wren();
    frame(8'h02, 8'h12, 8'h34, 8'h56, 8'h9A, 0, 5);
    chk("R5 program issued", got_req, 1);
    chk("R5 program kind", c_kind, 0);
    chk("R5 program addr", c_addr, 24'h123456);
    chk("R5 program data", c_data, 16'h009A);
    rd_stat(8'h05, s);
    chk("R5 latch cleared", s, 8'hA5);
    wren();
    frame(8'h02, 8'h12, 8'h34, 8'h56, 8'h9A, 8'h11, 6);
    chk("R5 two data bytes rejected", got_req, 0);
    rd_stat(8'h05, s);
    chk("R5 latch kept after reject", s, 8'hA7);

    // R2 aborts
    cs_on(); xb(8'h02, r); xb(8'h00, r); xb(8'h10, r); xb(8'h00, r); bits(8'hFF, 5, r); cs_off();
    chk("R2 aborted program", got_req, 0);
    rd_stat(8'h05, s);
    chk("R2 latch kept", s, 8'hA7);
    cs_on(); bits(8'h04, 5, r); cs_off();
    rd_stat(8'h05, s);
    chk("R2 partial disable ignored", s, 8'hA7);
    frame(8'h04, 0, 0, 0, 0, 0, 1);
    cs_on(); bits(8'h06, 7, r); cs_off();
    rd_stat(8'h05, s);
    chk("R2 partial enable ignored", s, 8'hA5);

    // R6 erase sweep
    for (int e = 0; e < 3; e++)
      for (int k = 0; k < 4; k++) begin
        wren();
        frame(eops[e], eaddr[k][23:16], eaddr[k][15:8], eaddr[k][7:0], 0, 0, 4);
        chk("R6 erase issued", got_req, 1);
        chk("R6 erase kind", c_kind, 3'(e + 1));
        chk("R6 erase masked addr", c_addr, (eaddr[k] >> emask[e]) << emask[e]);
      end

    // R7 chip erase
    wren(); frame(8'h60, 0, 0, 0, 0, 0, 1);
    chk("R7 chip erase 60h", {got_req, c_kind, c_addr}, {1'b1, 3'd4, 24'h0});
    wren(); frame(8'hC7, 0, 0, 0, 0, 0, 1);
    chk("R7 chip erase C7h", {got_req, c_kind, c_addr}, {1'b1, 3'd4, 24'h0});

    // R8 status write
    wren(); frame(8'h01, 8'h5C, 0, 0, 0, 0, 2);
    chk("R8 one byte", {got_req, c_kind, c_data, c_two}, {1'b1, 3'd5, 16'h005C, 1'b0});
    wren(); frame(8'h01, 8'h81, 8'h42, 0, 0, 0, 3);
    chk("R8 two bytes", {got_req, c_kind, c_data, c_two}, {1'b1, 3'd5, 16'h8142, 1'b1});

    // R9 read, R1 address assembly
    for (int k = 0; k < 4; k++) begin
      a = (k == 3) ? 24'hFFFFFE : eaddr[k] + 24'(k * 77);
      cs_on(); xb(8'h03, r); xb(a[23:16], r); xb(a[15:8], r); xb(a[7:0], r);
      for (int i = 0; i < 4; i++) begin
        xb(0, r); chk("R9 read stream", r, arr(a + 24'(i)));
      end
      cs_off();
    end

    // R10 fast read
    a = 24'h0A0B0C;
    cs_on(); xb(8'h0B, r); xb(a[23:16], r); xb(a[15:8], r); xb(a[7:0], r); xb(8'h00, r);
    for (int i = 0; i < 3; i++) begin
      xb(0, r); chk("R10 fast read stream", r, arr(a + 24'(i)));
    end
    cs_off();

    // R12 identification
    cs_on(); xb(8'h90, r); xb(0, r); xb(0, r); xb(8'h00, r);
    xb(0, r); chk("R12 A0=0 first", r, 8'hBF);
    xb(0, r); chk("R12 A0=0 second", r, 8'h8C);
    xb(0, r); chk("R12 A0=0 third", r, 8'hBF);
    cs_off();
    cs_on(); xb(8'hAB, r); xb(0, r); xb(0, r); xb(8'h01, r);
    xb(0, r); chk("R12 A0=1 first", r, 8'h8C);
    xb(0, r); chk("R12 A0=1 second", r, 8'hBF);
    cs_off();

    // R13 JEDEC
    cs_on(); xb(8'h9F, r);
    for (int i = 0; i < 6; i++) begin
      xb(0, r);
      chk("R13 jedec stream", r, (i % 3 == 0) ? 8'hBF : (i % 3 == 1) ? 8'h25 : 8'h8C);
    end
    cs_off();

    // R14 unknown opcode sweep with latch set
    wren();
    for (int op = 0; op < 256; op++) begin
      skip = 1'b0;
      for (int j = 0; j < 16; j++) if (known[j] == 8'(op)) skip = 1'b1;
      if (!skip) begin
        frame(8'(op), 8'hFF, 8'hFF, 8'hFF, 8'hFF, 0, 5);
        chk("R14 no output enable", oe_seen, 0);
        chk("R14 no request", got_req, 0);
      end
    end
    rd_stat(8'h05, s);
    chk("R14 latch unchanged", s, 8'hA7);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule